// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 20-bit virtual page number into a final page table entry by walking a two-level table held in memory. A requester hands it the page number together with the physical base of the top-level (master) table. The walker reads the master entry, and when that entry is valid it reads the secondary entry, which sits in the page frame the master entry names. It then reports either the secondary entry or a page fault that says which level was invalid.

Pages are 4 KB. The page number splits into a 10-bit master index (upper half, virtual address bits 31:22) and a 10-bit secondary index (lower half, virtual address bits 21:12). Each table holds 1024 four-byte entries, so one table fills one page. The block reaches memory through a word-read port with a valid/ready request channel and a response-valid channel. It keeps one memory read in flight at a time and serves one walk at a time.

Entry format: bit 31 modified, bit 30 referenced, bit 29 valid, bits 28:26 read/write/execute permission, bits 25:20 reserved, bits 19:0 page frame number.

Top module: `pt_walker`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1, `done` is 0 and `mem_req_valid` is 0.
- R2: The first memory read of a walk uses the address `req_base + 4 * req_vpn[19:10]`.
- R3: When bit 29 of the master entry is 0, the walk ends after exactly one memory read. `done` is raised with `done_fault`=1, `fault_lvl`=0 and `done_pte`=0.
- R4: When the master entry is valid, the second read uses the address `{master[19:0], req_vpn[9:0], 2'b00}`.
- R5: When bit 29 of the secondary entry is 0, the walk ends after exactly two reads with `done_fault`=1, `fault_lvl`=1 and `done_pte`=0.
- R6: When both entries are valid, the walk ends after exactly two reads with `done_fault`=0. `done_pte` equals the secondary entry with bits 25:20 forced to 0.
- R7: `done` is high for exactly one cycle per accepted request.
- R8: `req_ready` is 1 only while idle. A `req_valid` held high during a walk does not start a second walk.
- R9: A memory request that is not yet accepted keeps `mem_req_valid` high and `mem_req_addr` unchanged.
- R10: A reset during a walk returns the block to idle. A memory response that arrives afterwards produces no `done` and is ignored.
- R11: After a memory request is accepted, `mem_req_valid` stays low until the response for it has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle, request taken this cycle |
| req_vpn | input | 20 | Virtual page number to translate |
| req_base | input | 32 | Physical address of the master table |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Word address of the entry read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Read data |
| done | output | 1 | One-cycle walk completion pulse |
| done_pte | output | 32 | Final entry, reserved bits cleared; zero on fault |
| done_fault | output | 1 | Walk ended in a page fault |
| fault_lvl | output | 1 | Faulting level: 0 master, 1 secondary |

## Verification
Walks are driven against a sparse memory model in several forms. A fully valid walk whose secondary entry has its reserved bits set separates correct masking and the two address computations from a faulting result. A walk with an unmapped master slot and a walk with an invalid secondary entry tell the two fault levels apart through the fault level and the read count. A walk at the top indices, under back-pressure and response latency, exposes address carries and request stability. Holding the request line high through a walk, and resetting in the middle of a walk while a stale response is still on its way, show whether a second walk starts or a spurious completion appears.

// File: rtl/pt_walker_pkg.sv
// Shared constants and the walk state type for the page table walker.
// Assumes the 32-bit entry layout given in the brief.
package pt_walker_pkg;
    localparam int PTE_W  = 32;
    localparam int V_BIT  = 29;
    localparam int RSV_LO = 20;
    localparam int RSV_HI = 25;
    localparam logic [PTE_W-1:0] RSV_MASK =
        PTE_W'(((64'd1 << (RSV_HI - RSV_LO + 1)) - 64'd1) << RSV_LO);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_DONE
    } walk_st_t;
endpackage

// File: rtl/pt_walk_addr.sv
// Entry address generator.
// Forms the master entry address (base plus scaled master index) or the
// secondary entry address (frame number shifted to a page boundary plus the
// scaled secondary index). Assumes 4-byte entries.
module pt_walk_addr #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int PFN_W  = 20,
    parameter int OFF_W  = 12
) (
    input  logic              sel_l2,
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx_top,
    input  logic [IDX_W-1:0]  idx_sec,
    input  logic [PFN_W-1:0]  pfn,
    output logic [ADDR_W-1:0] addr
);
    localparam int ENT_SH = 2;

    logic [ADDR_W-1:0] l1_addr;
    logic [ADDR_W-1:0] l2_addr;

    // Master entry address: table base plus four bytes per index step.
    assign l1_addr = base + ADDR_W'({idx_top, {ENT_SH{1'b0}}});
    // Secondary entry address: table page start plus four bytes per index step.
    assign l2_addr = ADDR_W'({pfn, {OFF_W{1'b0}}}) + ADDR_W'({idx_sec, {ENT_SH{1'b0}}});
    // Pick the level being read.
    assign addr = sel_l2 ? l2_addr : l1_addr;
endmodule

// File: rtl/pt_entry_dec.sv
// Entry decoder.
// Extracts the valid bit and frame number from a fetched entry and builds
// the entry as returned to the requester, with the reserved field zeroed.
module pt_entry_dec #(
    parameter int PFN_W = 20
) (
    input  logic [pt_walker_pkg::PTE_W-1:0] raw,
    output logic                            ent_valid,
    output logic [PFN_W-1:0]                ent_pfn,
    output logic [pt_walker_pkg::PTE_W-1:0] ent_clean
);
    import pt_walker_pkg::*;

    // Field extraction and reserved-field clearing.
    assign ent_valid = raw[V_BIT];
    assign ent_pfn   = raw[PFN_W-1:0];
    assign ent_clean = raw & ~RSV_MASK;
endmodule

// File: rtl/pt_walk_ctrl.sv
// Walk sequencer.
// Takes one request while idle, issues the master read, then the secondary
// read if the master entry is valid, and posts a one-cycle completion with an
// entry or a fault. Assumes memory returns exactly one response per accepted
// read; responses seen outside a wait state are ignored.
module pt_walk_ctrl #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int PFN_W  = 20
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    output logic                            req_ready,
    input  logic [2*IDX_W-1:0]              req_vpn,
    input  logic [ADDR_W-1:0]               req_base,
    output logic                            mem_req_valid,
    input  logic                            mem_req_ready,
    input  logic                            mem_rsp_valid,
    input  logic                            ent_valid,
    input  logic [PFN_W-1:0]                ent_pfn,
    input  logic [pt_walker_pkg::PTE_W-1:0] ent_clean,
    output logic                            sel_l2,
    output logic [ADDR_W-1:0]               base_q,
    output logic [IDX_W-1:0]                idx_top,
    output logic [IDX_W-1:0]                idx_sec,
    output logic [PFN_W-1:0]                pfn_q,
    output logic                            done,
    output logic [pt_walker_pkg::PTE_W-1:0] done_pte,
    output logic                            done_fault,
    output logic                            fault_lvl
);
    import pt_walker_pkg::*;

    walk_st_t                  state;
    logic [2*IDX_W-1:0]        vpn_q;
    logic [PTE_W-1:0]          pte_q;
    logic                      fault_q;
    logic                      lvl_q;

    // Request state machine with captured walk context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            vpn_q   <= '0;
            base_q  <= '0;
            pfn_q   <= '0;
            pte_q   <= '0;
            fault_q <= 1'b0;
            lvl_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    vpn_q  <= req_vpn;
                    base_q <= req_base;
                    state  <= ST_L1_REQ;
                end
                ST_L1_REQ: if (mem_req_ready) state <= ST_L1_WAIT;
                ST_L1_WAIT: if (mem_rsp_valid) begin
                    if (ent_valid) begin
                        pfn_q <= ent_pfn;
                        state <= ST_L2_REQ;
                    end else begin
                        pte_q   <= '0;
                        fault_q <= 1'b1;
                        lvl_q   <= 1'b0;
                        state   <= ST_DONE;
                    end
                end
                ST_L2_REQ: if (mem_req_ready) state <= ST_L2_WAIT;
                ST_L2_WAIT: if (mem_rsp_valid) begin
                    pte_q   <= ent_valid ? ent_clean : '0;
                    fault_q <= ~ent_valid;
                    lvl_q   <= ~ent_valid;
                    state   <= ST_DONE;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state.
    assign req_ready     = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_L1_REQ) || (state == ST_L2_REQ);
    assign sel_l2        = (state == ST_L2_REQ);
    assign idx_top       = vpn_q[2*IDX_W-1:IDX_W];
    assign idx_sec       = vpn_q[IDX_W-1:0];
    assign done          = (state == ST_DONE);
    assign done_pte      = pte_q;
    assign done_fault    = fault_q;
    assign fault_lvl     = lvl_q;
endmodule

// File: rtl/pt_walker.sv
// Two-level page table walker top.
// Connects the sequencer, the entry address generator and the entry decoder.
// Assumes ADDR_W equals PFN_W + OFF_W and word-aligned table bases.
module pt_walker #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10,
    parameter int PFN_W  = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [2*IDX_W-1:0]  req_vpn,
    input  logic [ADDR_W-1:0]   req_base,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [ADDR_W-1:0]   mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [31:0]         mem_rsp_data,
    output logic                done,
    output logic [31:0]         done_pte,
    output logic                done_fault,
    output logic                fault_lvl
);
    logic              ent_valid;
    logic [PFN_W-1:0]  ent_pfn;
    logic [31:0]       ent_clean;
    logic              sel_l2;
    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  idx_top;
    logic [IDX_W-1:0]  idx_sec;
    logic [PFN_W-1:0]  pfn_q;

    pt_walk_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PFN_W(PFN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vpn(req_vpn), .req_base(req_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .ent_valid(ent_valid), .ent_pfn(ent_pfn), .ent_clean(ent_clean),
        .sel_l2(sel_l2), .base_q(base_q), .idx_top(idx_top), .idx_sec(idx_sec),
        .pfn_q(pfn_q),
        .done(done), .done_pte(done_pte), .done_fault(done_fault),
        .fault_lvl(fault_lvl)
    );

    pt_walk_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PFN_W(PFN_W), .OFF_W(OFF_W)) u_addr (
        .sel_l2(sel_l2), .base(base_q), .idx_top(idx_top), .idx_sec(idx_sec),
        .pfn(pfn_q), .addr(mem_req_addr)
    );

    pt_entry_dec #(.PFN_W(PFN_W)) u_dec (
        .raw(mem_rsp_data), .ent_valid(ent_valid), .ent_pfn(ent_pfn),
        .ent_clean(ent_clean)
    );
endmodule

// File: rtl/pt_walker_chk.sv
// Protocol checker for the page table walker, bound to every instance.
// Assumes the default 32-bit widths.
module pt_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        mem_rsp_valid,
    input logic        done,
    input logic [31:0] done_pte,
    input logic        done_fault
);
    // R7: completion is a single-cycle pulse.
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: an accepted request makes the walker busy.
    p_busy_after_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9: a stalled memory request stays put.
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R11: no back-to-back memory requests without a response between.
    p_one_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    // R6: a successful entry is valid with its reserved field clear.
    p_clean_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_fault) |-> (done_pte[29] && (done_pte[25:20] == 6'd0)));

    // R3: a faulting completion carries no entry.
    p_fault_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_fault) |-> (done_pte == 32'd0));

    // R10: no memory request while the walker is idle.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid);

    logic unused_rsp;
    assign unused_rsp = mem_rsp_valid;
endmodule

bind pt_walker pt_walker_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .done(done), .done_pte(done_pte), .done_fault(done_fault)
);

// File: tb/pt_walker_tb_top.sv
// Scoreboard bench: the driver task predicts each walk from the memory model
// and queues it; the monitor pops and compares on every completion.
module pt_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_vpn = '0;
    logic [31:0] req_base = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done;
    logic [31:0] done_pte;
    logic        done_fault;
    logic        fault_lvl;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    pt_walker dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vpn(req_vpn), .req_base(req_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .done_pte(done_pte),
        .done_fault(done_fault), .fault_lvl(fault_lvl)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Sparse memory model.
    logic [31:0] mem [logic [31:0]];
    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    int  lat = 0;
    bit  stall_mode = 1'b0;
    int  acc_total = 0;
    bit  pend = 1'b0;
    int  pend_cnt = 0;
    logic [31:0] pend_addr = '0;
    int  cyc = 0;

    // Memory responder; decisions at the falling edge, seen at the next rising edge.
    always @(negedge clk) begin
        bit rdy;
        cyc++;
        mem_rsp_valid = 1'b0;
        if (pend) begin
            if (pend_cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rd(pend_addr);
                pend = 1'b0;
            end else pend_cnt--;
        end
        rdy = stall_mode ? cyc[0] : 1'b1;
        mem_req_ready = rdy;
        if (rst_n && mem_req_valid && rdy && !pend) begin
            pend      = 1'b1;
            pend_cnt  = lat;
            pend_addr = mem_req_addr;
            acc_total++;
        end
    end

    typedef struct {
        logic [31:0] pte;
        logic        fault;
        logic        lvl;
        int          reads;
        int          start;
    } exp_t;
    exp_t sb[$];
    int done_cnt = 0;

    // Monitor: compare every completion with the oldest prediction.
    always @(negedge clk) begin
        if (rst_n && done) begin
            done_cnt++;
            if (sb.size() == 0) begin
                chk(1'b0, "R7/R10 unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(done_pte == e.pte, "R6 entry", done_pte, e.pte);
                chk(done_fault == e.fault, "R3/R5 fault flag", 32'(done_fault), 32'(e.fault));
                if (e.fault)
                    chk(fault_lvl == e.lvl, "R3/R5 fault level", 32'(fault_lvl), 32'(e.lvl));
                chk(acc_total - e.start == e.reads, "R2/R4 read count",
                    32'(acc_total - e.start), 32'(e.reads));
            end
        end
    end

    // Driver: predict from the entry rules, queue, then issue the request.
    task automatic walk(input logic [31:0] base, input logic [19:0] vpn, input bit hold);
        exp_t e;
        logic [31:0] m, s;
        int target;
        m = rd(base + {20'd0, vpn[19:10], 2'b00});
        if (!m[29]) begin
            e.pte = 32'd0; e.fault = 1'b1; e.lvl = 1'b0; e.reads = 1;
        end else begin
            s = rd({m[19:0], vpn[9:0], 2'b00});
            e.reads = 2;
            if (!s[29]) begin
                e.pte = 32'd0; e.fault = 1'b1; e.lvl = 1'b1;
            end else begin
                e.pte = s & ~32'h03F0_0000; e.fault = 1'b0; e.lvl = 1'b0;
            end
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        e.start = acc_total;
        sb.push_back(e);
        target = done_cnt + 1;
        req_base = base; req_vpn = vpn; req_valid = 1'b1;
        @(negedge clk);
        if (!hold) req_valid = 1'b0;
        chk(req_ready == 1'b0, "R8 busy after accept", 32'(req_ready), 32'd0);
        while (done_cnt < target) @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Watchdog.
    initial begin
        #(20 * 20000);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        // Table contents.
        mem[32'h0010_000C] = 32'h2000_0200;   // master slot 3 -> frame 0x200
        mem[32'h0020_0014] = 32'hBBF0_0ABC;   // slot 5: valid, reserved bits set
        mem[32'h0020_0024] = 32'h5C00_0123;   // slot 9: invalid
        mem[32'h0003_0FFC] = 32'h2000_0FFF;   // master slot 1023 -> frame 0xFFF
        mem[32'h00FF_FFFC] = 32'h7C0F_FFFF;   // slot 1023: valid

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 32'd1);
        chk(done == 1'b0, "R1 done in reset", 32'(done), 32'd0);
        chk(mem_req_valid == 1'b0, "R1 mem idle in reset", 32'(mem_req_valid), 32'd0);
        rst_n = 1'b1;

        walk(32'h0010_0000, {10'd3, 10'd5}, 1'b0);     // R6 success, reserved masked
        walk(32'h0010_0000, {10'd7, 10'd5}, 1'b0);     // R3 master invalid
        walk(32'h0010_0000, {10'd3, 10'd9}, 1'b0);     // R5 secondary invalid
        lat = 3; stall_mode = 1'b1;
        walk(32'h0003_0000, {10'd1023, 10'd1023}, 1'b0); // R9 stalls, top indices
        lat = 0; stall_mode = 1'b0;
        walk(32'h0010_0000, {10'd3, 10'd5}, 1'b1);     // R8 request held high
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R8 no extra walk", 32'(sb.size()), 32'd0);

        // R10: reset with a read outstanding, stale response afterwards.
        lat = 6;
        req_base = 32'h0010_0000; req_vpn = {10'd3, 10'd5}; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!pend) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (12) @(negedge clk);
        chk(req_ready == 1'b1, "R10 idle after reset", 32'(req_ready), 32'd1);
        chk(mem_req_valid == 1'b0, "R10 no request after reset", 32'(mem_req_valid), 32'd0);
        chk(done_cnt == 5, "R10 stale response ignored", 32'(done_cnt), 32'd5);
        lat = 0;
        walk(32'h0010_0000, {10'd3, 10'd5}, 1'b0);     // R10 clean walk after reset
        chk(done_cnt == 6, "R7 one done per request", 32'(done_cnt), 32'd6);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule